// File: doc/BRIEF.md
# Synchronous Burst Read Address Sequencer

This block sequences synchronous burst reads from a 16-bit-wide memory array. The host pulses an address-valid strobe while chip enable is active, and the block captures the start word address. After a configurable number of active clock edges, it raises a ready output. From then on it delivers one data word per active edge, and it keeps doing so until chip enable or output enable is withdrawn. The array is outside the block. It is a plain synchronous read port that returns, on each active edge, the word at the address the block issued on the previous edge. The block drives that address and a read strobe, and it passes the returned word through to the host alongside ready.

A configuration bit selects which clock edge is the active one, rising or falling. That edge is used for every capture, every count and every output step. A burst can wrap inside an aligned block of 8, 16 or 32 words. It can also run linearly through the whole array, and in that case it rolls over from the highest address to zero. The latency and the burst mode are captured together with the start address, so a burst keeps the settings it started with.

Top module: `burst_rd_seq`

## Requirements
- R1: The start address is captured only on an active edge where both `addr_vld` and `chip_en` are high. An `addr_vld` pulse with `chip_en` low leaves `rdy` and `mem_rd` low.
- R2: Let L be the effective latency. L equals `lat_cfg` for values 2 to 7, and a `lat_cfg` of 0 or 1 acts as 2. Let the capture edge be edge 0. Then `rdy` is low after edges 1 to L-1 and high after edge L.
- R3: While `rdy` is high, `dout` holds one word per active edge, taken in burst order with no gaps or repeats. The first word is the one at the start address.
- R4: `wrap_sel` selects the burst mode: 0 gives 8 words, 1 gives 16 words, 2 gives 32 words, and 3 gives linear. In the three wrap modes, only the low log2(length) address bits increment. They wrap to zero inside the aligned block, and the upper bits stay constant.
- R5: In linear mode (`wrap_sel` = 3), the address increments by one per word and rolls over from 2^AW-1 to 0.
- R6: If `chip_en` or `out_en` is low at an active edge during a burst, `rdy` and `mem_rd` are low after that edge and stay low until the next capture.
- R7: With `edge_fall` high, all capture, counting and stepping happen on falling clock edges, and outputs change only at falling edges. With `edge_fall` low, all of this happens on rising edges.
- R8: `lat_cfg` and `wrap_sel` are sampled at the capture edge. Changing them during a burst does not alter that burst's latency or address order.
- R9: While reset is asserted, `rdy` and `mem_rd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| edge_fall | input | 1 | 1: falling edge is active; 0: rising edge |
| lat_cfg | input | 3 | Initial latency in active edges (2 to 7) |
| wrap_sel | input | 2 | Burst mode: 0/1/2 wrap 8/16/32, 3 linear |
| chip_en | input | 1 | Chip enable, active high |
| out_en | input | 1 | Output enable, active high |
| addr_vld | input | 1 | Address-valid strobe, active high |
| start_addr | input | AW | Start word address |
| mem_addr | output | AW | Word address issued to the array |
| mem_rd | output | 1 | Read strobe to the array |
| mem_rdata | input | DW | Word returned by the array one active edge after its address |
| rdy | output | 1 | Output word on `dout` is valid |
| dout | output | DW | Data word to the host |

## Verification
The assertions assume that `edge_fall` changes only while reset is held. A change at any other time would create a spurious edge on the derived active clock. The stimulus therefore selects the polarity inside each reset sequence. The assertions also assume that host inputs are stable around the active edge and that `out_en` stays high from the capture onward, except when it is dropped on purpose to end a burst. The bench drives all inputs on the inactive clock edge and raises `out_en` together with the capture strobe.

// File: rtl/brs_pkg.sv
package brs_pkg;

  localparam int LAT_W = 3;

  typedef enum logic [1:0] {
    MODE_W8  = 2'd0,
    MODE_W16 = 2'd1,
    MODE_W32 = 2'd2,
    MODE_LIN = 2'd3
  } burst_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_e;

  // Latency settings below two are raised to two.
  function automatic logic [LAT_W-1:0] eff_latency(input logic [LAT_W-1:0] cfg);
    return (cfg < LAT_W'(2)) ? LAT_W'(2) : cfg;
  endfunction

endpackage

// File: rtl/brs_clk_pol.sv
module brs_clk_pol (
  input  logic clk,
  input  logic edge_fall,
  output logic act_clk
);
  // An inverted clock turns the falling edge into the sampling edge.
  assign act_clk = clk ^ edge_fall;
endmodule

// File: rtl/brs_lat_ctr.sv
module brs_lat_ctr #(
  parameter int LW = 3
) (
  input  logic          act_clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] load_val,
  output logic          expire
);
  logic [LW-1:0] cnt;

  always_ff @(posedge act_clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - LW'(1);
  end

  assign expire = (cnt == LW'(1));
endmodule

// File: rtl/brs_addr_gen.sv
module brs_addr_gen
  import brs_pkg::*;
#(
  parameter int AW = 22
) (
  input  logic          act_clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          step,
  input  burst_mode_e   mode,
  output logic [AW-1:0] addr
);
  // The low bits advance; a wrap mode freezes everything above the block size.
  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a,
                                              input burst_mode_e m);
    logic [AW-1:0] n;
    case (m)
      MODE_W8:  n = {a[AW-1:3], a[2:0] + 3'd1};
      MODE_W16: n = {a[AW-1:4], a[3:0] + 4'd1};
      MODE_W32: n = {a[AW-1:5], a[4:0] + 5'd1};
      default:  n = a + AW'(1);
    endcase
    return n;
  endfunction

  always_ff @(posedge act_clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_addr;
    else if (step) addr <= next_addr(addr, mode);
  end
endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
  import brs_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                edge_fall,
  input  logic [LAT_W-1:0]    lat_cfg,
  input  logic [1:0]          wrap_sel,
  input  logic                chip_en,
  input  logic                out_en,
  input  logic                addr_vld,
  input  logic [AW-1:0]       start_addr,
  output logic [AW-1:0]       mem_addr,
  output logic                mem_rd,
  input  logic [DW-1:0]       mem_rdata,
  output logic                rdy,
  output logic [DW-1:0]       dout
);

  logic        act_clk;
  seq_state_e  state;
  burst_mode_e mode_q;
  logic        capture_ev, abort_ev, issue_ev, step_ev, lat_done, busy;
  logic [LAT_W-1:0] lat_load;

  brs_clk_pol u_pol (
    .clk       (clk),
    .edge_fall (edge_fall),
    .act_clk   (act_clk)
  );

  // Named events shared by the control logic and the checker.
  assign capture_ev = addr_vld & chip_en;
  assign busy       = (state != ST_IDLE);
  assign abort_ev   = busy & ~(chip_en & out_en);
  assign issue_ev   = (state == ST_WAIT) & lat_done & ~abort_ev & ~capture_ev;
  assign step_ev    = (state == ST_RUN) & ~abort_ev & ~capture_ev;
  assign lat_load   = eff_latency(lat_cfg) - LAT_W'(1);

  brs_lat_ctr #(.LW(LAT_W)) u_lat (
    .act_clk  (act_clk),
    .rst_n    (rst_n),
    .load     (capture_ev),
    .load_val (lat_load),
    .expire   (lat_done)
  );

  brs_addr_gen #(.AW(AW)) u_agen (
    .act_clk   (act_clk),
    .rst_n     (rst_n),
    .load      (capture_ev),
    .load_addr (start_addr),
    .step      (step_ev),
    .mode      (mode_q),
    .addr      (mem_addr)
  );

  always_ff @(posedge act_clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      mode_q <= MODE_W8;
      mem_rd <= 1'b0;
      rdy    <= 1'b0;
    end else if (capture_ev) begin
      state  <= ST_WAIT;
      mode_q <= burst_mode_e'(wrap_sel);
      mem_rd <= 1'b0;
      rdy    <= 1'b0;
    end else if (abort_ev) begin
      state  <= ST_IDLE;
      mem_rd <= 1'b0;
      rdy    <= 1'b0;
    end else begin
      // The array answers one edge after the request, so ready trails the strobe.
      rdy <= mem_rd;
      if (issue_ev) begin
        state  <= ST_RUN;
        mem_rd <= 1'b1;
      end
    end
  end

  assign dout = mem_rdata;

endmodule

// File: rtl/brs_chk.sv
module brs_chk
  import brs_pkg::*;
#(
  parameter int AW = 22
) (
  input logic          act_clk,
  input logic          rst_n,
  input logic          capture_ev,
  input logic          abort_ev,
  input logic          step_ev,
  input logic          busy,
  input logic          rdy,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr,
  input burst_mode_e   mode_q
);

  // R1
  idle_quiet_chk: assert property (@(posedge act_clk) disable iff (!rst_n)
    (!busy && !capture_ev) |=> !mem_rd);

  // R2
  lat_gap_chk: assert property (@(posedge act_clk) disable iff (!rst_n)
    capture_ev |=> (!rdy && !mem_rd));

  // R3
  rdy_after_req_chk: assert property (@(posedge act_clk) disable iff (!rst_n)
    rdy |-> $past(mem_rd));

  // R4
  wrap_block_chk: assert property (@(posedge act_clk) disable iff (!rst_n)
    (step_ev && mode_q != MODE_LIN) |=> $stable(mem_addr[AW-1:5]));

  // R5
  linear_step_chk: assert property (@(posedge act_clk) disable iff (!rst_n)
    (step_ev && mode_q == MODE_LIN) |=> (mem_addr == AW'($past(mem_addr) + 1'b1)));

  // R6
  abort_drop_chk: assert property (@(posedge act_clk) disable iff (!rst_n)
    (abort_ev && !capture_ev) |=> (!rdy && !mem_rd));

endmodule

bind burst_rd_seq brs_chk #(.AW(AW)) u_chk (.*);

// File: tb/burst_rd_seq_bench.sv
module burst_rd_seq_bench;
  localparam int AW = 22;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          edge_fall = 1'b0;
  logic [2:0]    lat_cfg = 3'd2;
  logic [1:0]    wrap_sel = 2'd0;
  logic          chip_en = 1'b0, out_en = 1'b0, addr_vld = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, rdy;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] dout;

  int n_cmp = 0, n_bad = 0;
  logic [AW-1:0] exp_q[$];

  burst_rd_seq #(.AW(AW), .DW(DW)) u_burst_rd_seq (.*);

  always #10 clk = ~clk;   // 50 MHz

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return a[15:0] ^ {a[21:16], 10'h1A5};
  endfunction

  // Burst order: an aligned window of 8<<mode words, or a plain modular count.
  function automatic logic [AW-1:0] word_addr(input logic [AW-1:0] st,
                                              input logic [1:0] mode, input int i);
    logic [AW-1:0] sum, msk;
    sum = st + AW'(i);
    if (mode == 2'd3) return sum;
    msk = AW'((8 << mode) - 1);
    return (st & ~msk) | (sum & msk);
  endfunction

  // Synchronous array model on the active edge.
  always @(posedge clk) if (!edge_fall) mem_rdata <= pat(mem_addr);
  always @(negedge clk) if (edge_fall)  mem_rdata <= pat(mem_addr);

  task automatic wait_s();
    if (edge_fall) @(posedge clk); else @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Monitor: pop and compare every word presented with rdy.
  task automatic mon_cmp();
    logic [AW-1:0] a;
    if (exp_q.size() == 0) begin
      check(1'b0, "R3 unexpected word", 32'(dout), 32'hFFFF_FFFF);
    end else begin
      a = exp_q.pop_front();
      check(dout == pat(a), "R3 R4 R5 word order", 32'(dout), 32'(pat(a)));
    end
  endtask

  always @(posedge clk) if (rst_n && edge_fall && rdy)  mon_cmp();
  always @(negedge clk) if (rst_n && !edge_fall && rdy) mon_cmp();

  task automatic do_reset(input logic fall);
    rst_n = 1'b0; chip_en = 1'b0; out_en = 1'b0; addr_vld = 1'b0;
    edge_fall = fall;
    repeat (3) @(posedge clk);
    #3;
    // R9
    check(!rdy && !mem_rd, "R9 reset quiet", {rdy, mem_rd}, 0);
    rst_n = 1'b1;
  endtask

  // Driver: start a burst, push its expected words, end it after n words.
  task automatic burst(input logic [AW-1:0] st, input logic [2:0] lat,
                       input logic [1:0] mode, input int n,
                       input bit by_oe, input bit swap_cfg);
    int eff;
    eff = (lat < 3'd2) ? 2 : int'(lat);
    wait_s();
    start_addr = st; lat_cfg = lat; wrap_sel = mode;
    addr_vld = 1'b1; chip_en = 1'b1; out_en = 1'b1;
    for (int i = 0; i < n; i++) exp_q.push_back(word_addr(st, mode, i));
    wait_s();
    addr_vld = 1'b0;
    if (swap_cfg) begin
      // R8: new settings must not reach the running burst
      lat_cfg = 3'd7; wrap_sel = ~mode;
    end
    repeat (eff - 1) wait_s();
    check(!rdy, "R2 R8 early ready", 32'(rdy), 0);
    wait_s();
    check(rdy, "R2 R8 ready at latency", 32'(rdy), 1);
    repeat (n - 1) wait_s();
    if (by_oe) out_en = 1'b0; else chip_en = 1'b0;
    wait_s();
    // R6
    check(!rdy && !mem_rd, "R6 abort drop", {rdy, mem_rd}, 0);
    check(exp_q.size() == 0, "R3 words left", exp_q.size(), 0);
    chip_en = 1'b0; out_en = 1'b0;
    repeat (2) wait_s();
  endtask

  initial begin
    do_reset(1'b0);
    repeat (2) wait_s();

    // R1: strobe without chip enable is ignored
    wait_s();
    out_en = 1'b1; chip_en = 1'b0; addr_vld = 1'b1; start_addr = 22'h0000AA;
    wait_s();
    addr_vld = 1'b0;
    begin
      bit quiet = 1'b1;
      for (int i = 0; i < 8; i++) begin
        wait_s();
        if (rdy || mem_rd) quiet = 1'b0;
      end
      check(quiet, "R1 ignored strobe", 32'(quiet), 1);
    end
    out_en = 1'b0;

    burst(22'h000105, 3'd4, 2'd0, 12, 1'b0, 1'b0);   // R4 wrap 8
    burst(22'h00123E, 3'd2, 2'd1, 20, 1'b1, 1'b0);   // R4 wrap 16, R6 via out_en
    burst(22'h2ABC1D, 3'd7, 2'd2, 40, 1'b0, 1'b0);   // R4 wrap 32
    burst(22'h3FFFFD, 3'd3, 2'd3, 10, 1'b0, 1'b0);   // R5 rollover
    burst(22'h000040, 3'd0, 2'd3, 5,  1'b1, 1'b0);   // R2 clamp to 2
    burst(22'h000010, 3'd5, 2'd0, 11, 1'b0, 1'b1);   // R8 latched settings

    // R7: falling-edge operation
    do_reset(1'b1);
    repeat (2) wait_s();
    burst(22'h1FFFF3, 3'd3, 2'd1, 18, 1'b0, 1'b0);
    burst(22'h3FFFFE, 3'd6, 2'd3, 6,  1'b1, 1'b0);

    check(exp_q.size() == 0, "R3 final queue", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule